// File: doc/BRIEF.md
# Direction-Controlled General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port with an output latch and a per-bit direction register. Both are reached over a small synchronous register bus. When a bit's direction is set, the pin drives the value held in the latch. When the direction bit is clear, the pin is only sampled, through a two-stage synchronizer. A read of the port returns a mix: the latch for output bits and the synchronized pin level for input bits. The two lowest bits are wired as permanent inputs because they also carry interrupt requests. They can never be made to drive.

An operating-mode input and an external-clock-enable input decide whether each register is visible in the local map. An access to a register that is not mapped, or to an address that has no register, is not served locally. Instead the block raises a forward flag in that same cycle so that the bus can echo the access externally, and the local read data stays at zero. Software can load the latch first and turn the output on afterwards. The pin then starts driving the already stored value, with no intermediate level.

Top module: `gpio_dir_port`

## Requirements
- R1: A direction bit of 1 makes the matching pin drive (`pinOe` bit high) with the latch value on `pinOut`. A direction bit of 0 leaves it undriven. A mapped write to the direction register (address 1) shows on `pinOe` after the next rising edge.
- R2: Direction bits 1 and 0 are not implemented. They read back as 0, writes to them are ignored, and `pinOe[1:0]` is always 0.
- R3: After reset the direction register, the latch, `pinOut` and `pinOe` are all zero.
- R4: A read of the data register (address 0) returns the latch bit for bits whose direction is 1 and the synchronized pin level for bits whose direction is 0.
- R5: Bits 1 and 0 of a data-register read always return the synchronized pin level, even after a write of ones to those direction bits.
- R6: A pin change applied between edges appears in data-register read data only after the second following rising edge.
- R7: Mode encoding on `modeSel`: 0 normal single-chip, 1 expanded, 2 special peripheral, 3 special single-chip. The direction register is unmapped in modes 1 and 2. An access to it there raises `extAccess`, gives read data 0, and a write to it leaves `pinOe` unchanged.
- R8: The data register is unmapped in mode 2, and in mode 1 while `extClkEn` is 1. An access to it there raises `extAccess` with read data 0, and a write to it leaves `pinOut` unchanged. In every other case it is mapped.
- R9: Addresses 2 and 3 hold no register. Any access to them raises `extAccess` with read data 0.
- R10: Writing the latch while the direction bit is 0 changes `pinOut` but not `pinOe`. `pinOut` changes only on mapped data-register writes, so a later direction write enables the pin with the stored value already present.
- R11: When read and write strobes hit the same mapped register in one cycle, the read data shows the value held before the write. The write takes effect at that clock edge.
- R12: `extAccess` is high only in a cycle where `busRd` or `busWr` is high. With no strobe it is 0 whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Operating mode (0 single-chip, 1 expanded, 2 special peripheral, 3 special single-chip) |
| extClkEn | input | 1 | External clock enable; unmaps the data register in expanded mode |
| busAddr | input | 2 | Register address (0 data, 1 direction) |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| extAccess | output | 1 | Access is forwarded to the external bus this cycle |
| pinIn | input | 8 | Pin input levels |
| pinOut | output | 8 | Output latch value to the pins |
| pinOe | output | 8 | Per-pin output enable |

## Verification
Two things can land in the same cycle on this port: a register read, which is combinational, and a register write, which is clocked. The bench raises both strobes together on the data register, with new write data and with the direction set so that the latch is visible. It checks that the read in that cycle still shows the old latch, and that the new value appears right after the edge. A second overlap is a pin change against the synchronizer. The bench moves `pinIn` while a read is held open across three cycles, and accepts the new level only after the second edge.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_EXPANDED = 2'd1,
    MODE_PERIPH   = 2'd2,
    MODE_SPECIAL  = 2'd3
  } opMode_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
    logic extHit;
  } regStrobe_t;

endpackage

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl
  import gpio_dir_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int ADDR_DATA = 0,
  parameter int ADDR_DIR  = 1
) (
  input  logic [1:0]        modeSel,
  input  logic              extClkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output regStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(ADDR_DATA);
  localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(ADDR_DIR);

  opMode_e mode;
  logic dataMapped, dirMapped, hitData, hitDir, anyAccess;

  assign mode = opMode_e'(modeSel);

  // visibility of each register in the local map
  always_comb begin
    dataMapped = 1'b1;
    dirMapped  = 1'b1;
    unique case (mode)
      MODE_EXPANDED: begin
        dirMapped  = 1'b0;
        dataMapped = ~extClkEn;
      end
      MODE_PERIPH: begin
        dirMapped  = 1'b0;
        dataMapped = 1'b0;
      end
      default: ;
    endcase
  end

  assign hitData   = (busAddr == DATA_ADDR) && dataMapped;
  assign hitDir    = (busAddr == DIR_ADDR) && dirMapped;
  assign anyAccess = busWr | busRd;

  assign strb.wrData = busWr & hitData;
  assign strb.wrDir  = busWr & hitDir;
  assign strb.rdData = busRd & hitData;
  assign strb.rdDir  = busRd & hitDir;
  assign strb.extHit = anyAccess & ~(hitData | hitDir);

endmodule

// File: rtl/gpio_dir_dp.sv
module gpio_dir_dp
  import gpio_dir_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int INPUT_ONLY  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);

  localparam logic [DATA_W-1:0] DIR_MASK = {DATA_W{1'b1}} << INPUT_ONLY;

  logic [DATA_W-1:0] syncQ [SYNC_STAGES];
  logic [DATA_W-1:0] pinSync, dirQ, latchQ, portView;

  // pin synchronizer chain
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= pinIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  // direction register, input-only bits never stored
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           dirQ <= '0;
    else if (strb.wrDir) dirQ <= busWdata & DIR_MASK;

  // output latch
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            latchQ <= '0;
    else if (strb.wrData) latchQ <= busWdata;

  assign portView = (dirQ & latchQ) | (~dirQ & pinSync);

  always_comb begin
    busRdata = '0;
    if (strb.rdData)     busRdata = portView;
    else if (strb.rdDir) busRdata = dirQ;
  end

  assign pinOut = latchQ;
  assign pinOe  = dirQ;

endmodule

// File: rtl/gpio_dir_port.sv
module gpio_dir_port
  import gpio_dir_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int INPUT_ONLY  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_DATA   = 0,
  parameter int ADDR_DIR    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              extClkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              extAccess,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);

  regStrobe_t strb;

  gpio_dir_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR)
  ) u_ctrl (
    .modeSel(modeSel), .extClkEn(extClkEn), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  gpio_dir_dp #(
    .DATA_W(DATA_W), .INPUT_ONLY(INPUT_ONLY), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .pinIn(pinIn), .busRdata(busRdata), .pinOut(pinOut), .pinOe(pinOe)
  );

  assign extAccess = strb.extHit;

endmodule

// File: rtl/gpio_dir_port_chk.sv
module gpio_dir_port_chk #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int INPUT_ONLY = 2,
  parameter int ADDR_DATA  = 0,
  parameter int ADDR_DIR   = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              extClkEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              extAccess,
  input logic [DATA_W-1:0] pinOut,
  input logic [DATA_W-1:0] pinOe
);

  localparam logic [DATA_W-1:0] OE_MASK = {DATA_W{1'b1}} << INPUT_ONLY;

  logic dirVisible, dataVisible, dirWrite, dataWrite;
  assign dirVisible  = (modeSel == 2'd0) || (modeSel == 2'd3);
  assign dataVisible = (modeSel != 2'd2) && !((modeSel == 2'd1) && extClkEn);
  assign dirWrite    = busWr && (busAddr == ADDR_W'(ADDR_DIR));
  assign dataWrite   = busWr && (busAddr == ADDR_W'(ADDR_DATA));

  // R1
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrite && dirVisible) |=> (pinOe == ($past(busWdata) & OE_MASK)));

  // R2
  low_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirWrite |=> (pinOe[INPUT_ONLY-1:0] == '0));

  // R7
  dir_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrite && !dirVisible) |=> $stable(pinOe));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataWrite && dataVisible) |=> $stable(pinOut));

  // R9
  ext_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    extAccess |-> (busRdata == '0));

  // R12
  ext_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    extAccess |-> (busRd || busWr));

endmodule

bind gpio_dir_port gpio_dir_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INPUT_ONLY(INPUT_ONLY),
  .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR)
) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .extClkEn(extClkEn),
  .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
  .busRdata(busRdata), .extAccess(extAccess), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/gpio_dir_port_tb.sv
module gpio_dir_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       extClkEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       extAccess;
  logic [7:0] pinIn = 8'h00;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_dir_port u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .extClkEn(extClkEn),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .extAccess(extAccess), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] addr, output logic [7:0] data, output logic ext);
    @(negedge clk);
    busAddr = addr; busRd = 1'b1;
    #1;
    data = busRdata; ext = extAccess;
    busRd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d; logic e;
    chk("R3 pinOe", pinOe, 8'h00);
    chk("R3 pinOut", pinOut, 8'h00);
    busRead(2'd1, d, e);
    chk("R3 dir read", d, 8'h00);
  endtask

  task automatic testDirection();
    logic [7:0] d; logic e;
    busWrite(2'd1, 8'hF0);
    chk("R1 pinOe", pinOe, 8'hF0);
    busWrite(2'd0, 8'hA5);
    chk("R1 pinOut", pinOut, 8'hA5);
    busRead(2'd1, d, e);
    chk("R1 dir readback", d, 8'hF0);
  endtask

  task automatic testLowBits();
    logic [7:0] d; logic e;
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, d, e);
    chk("R2 dir read", d, 8'hFC);
    chk("R2 pinOe", pinOe, 8'hFC);
  endtask

  task automatic testReadMix();
    logic [7:0] d; logic e;
    pinIn = 8'h3E;
    busWrite(2'd1, 8'hF0);
    busWrite(2'd0, 8'hA5);
    settle();
    busRead(2'd0, d, e);
    chk("R4 mixed read", d, 8'hAE);
    busWrite(2'd1, 8'hFF);
    busRead(2'd0, d, e);
    chk("R5 low bits from pin", d, 8'hA6);
  endtask

  task automatic testSync();
    busWrite(2'd1, 8'h00);
    pinIn = 8'h3E;
    settle();
    @(negedge clk);
    pinIn = 8'h5A; busAddr = 2'd0; busRd = 1'b1;
    #1 chk("R6 before edge", busRdata, 8'h3E);
    @(negedge clk);
    #1 chk("R6 after one edge", busRdata, 8'h3E);
    @(negedge clk);
    #1 chk("R6 after two edges", busRdata, 8'h5A);
    busRd = 1'b0;
  endtask

  task automatic testModes();
    logic [7:0] d; logic e;
    modeSel = 2'd0; extClkEn = 1'b0;
    busWrite(2'd1, 8'hC0);
    busWrite(2'd0, 8'h81);
    modeSel = 2'd1;
    busRead(2'd1, d, e);
    chk("R7 exp dir ext", {7'd0, e}, 8'h01);
    chk("R7 exp dir data", d, 8'h00);
    busWrite(2'd1, 8'h00);
    chk("R7 hidden dir write", pinOe, 8'hC0);
    busRead(2'd0, d, e);
    chk("R8 exp data mapped", {7'd0, e}, 8'h00);
    extClkEn = 1'b1;
    busRead(2'd0, d, e);
    chk("R8 exp eclk data ext", {7'd0, e}, 8'h01);
    busWrite(2'd0, 8'h00);
    chk("R8 hidden data write", pinOut, 8'h81);
    extClkEn = 1'b0;
    modeSel = 2'd2;
    busRead(2'd0, d, e);
    chk("R8 periph data ext", {7'd0, e}, 8'h01);
    busRead(2'd1, d, e);
    chk("R7 periph dir ext", {7'd0, e}, 8'h01);
    modeSel = 2'd3;
    busRead(2'd1, d, e);
    chk("R7 special dir mapped", {7'd0, e}, 8'h00);
    chk("R7 special dir data", d, 8'hC0);
    modeSel = 2'd0;
    busRead(2'd2, d, e);
    chk("R9 addr2 ext", {7'd0, e}, 8'h01);
    chk("R9 addr2 data", d, 8'h00);
    busRead(2'd3, d, e);
    chk("R9 addr3 ext", {7'd0, e}, 8'h01);
    @(negedge clk);
    busAddr = 2'd3;
    #1 chk("R12 idle no ext", {7'd0, extAccess}, 8'h00);
  endtask

  task automatic testNoGlitch();
    busWrite(2'd1, 8'h00);
    busWrite(2'd0, 8'h80);
    chk("R10 oe held", pinOe, 8'h00);
    chk("R10 latch loaded", pinOut, 8'h80);
    @(negedge clk);
    busAddr = 2'd1; busWdata = 8'h80; busWr = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 oe on", pinOe, 8'h80);
    chk("R10 value at enable", pinOut, 8'h80);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic testSimul();
    busWrite(2'd1, 8'hFC);
    busWrite(2'd0, 8'h54);
    pinIn = 8'h00;
    settle();
    @(negedge clk);
    busAddr = 2'd0; busWdata = 8'h3C; busWr = 1'b1; busRd = 1'b1;
    #1 chk("R11 old value", busRdata, 8'h54);
    @(negedge clk);
    busWr = 1'b0;
    #1 chk("R11 new value", busRdata, 8'h3C);
    busRd = 1'b0;
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDirection();
    testLowBits();
    testReadMix();
    testSync();
    testModes();
    testNoGlitch();
    testSimul();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule